// File: doc/BRIEF.md
# Counter-Based Switch Debouncer

This block turns the raw level from a mechanical push-button or slide switch into a single clean level in the system clock domain. The raw pin is asynchronous and may bounce for several milliseconds after each press or release. It first passes through a flip-flop synchronizer, two stages by default. The synchronized value is then compared with the debounced output that the block currently presents.

A run counter measures how many consecutive clock cycles the synchronized input has disagreed with the output. Any single cycle of agreement clears the counter. Only when the disagreement has lasted a full window of 2^CNT_W cycles does the output take the new value. The counter is cleared on that cycle as well. A one-cycle strobe marks each accepted change.

Choose CNT_W so that the window is longer than the worst bounce at either level. A 16-bit counter at 10 MHz gives about 6.5 ms, and bounce can last anywhere from 1 ms to 20 ms. The block has no data stream, so there is no valid/ready handshake. All pins are plain levels.

Top module: `switch_debouncer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `btn_clean` equals the parameter IDLE_LVL (0 by default) and `btn_changed` is 0.
- R2: The raw input passes through SYNC_STAGES (default 2) synchronizer flops before comparison. A raw level held from clock edge k is first reflected in `btn_clean` after edge k + 2^CNT_W + SYNC_STAGES - 1, which is 18 edges including edge k for CNT_W = 4.
- R3: The output changes only after 2^CNT_W consecutive cycles in which the synchronized input differs from it. A disagreement lasting 2^CNT_W - 1 cycles leaves the output unchanged.
- R4: Any single cycle in which the synchronized input equals the output clears the run counter. An interrupted disagreement must then last a full window again before it is accepted.
- R5: On the cycle the output flips, the counter also returns to zero. A return to the old level right after a change therefore needs a whole new window to be accepted.
- R6: `btn_changed` is 1 for exactly one cycle: the cycle in which `btn_clean` first shows its new value. It is 0 in every other cycle.
- R7: A burst of bounce in which every run of equal raw values is shorter than the window never changes the output. A stable hold of at least the window plus the synchronizer delay that follows the burst changes the output exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Asynchronous, bouncing switch level |
| btn_clean | output | 1 | Debounced level, registered |
| btn_changed | output | 1 | One-cycle strobe on each accepted change |

## Verification
The bench targets the window boundary: a run one cycle shorter than the window must be rejected, and a run of exactly the window must be accepted. A counter that compared against the wrong limit would accept the short run or reject the exact one. It interrupts a nearly complete run with a single agreeing cycle. A design that only paused the counter, instead of clearing it, would flip too early. It reverses the input right after an accepted change, which exposes a counter left non-zero at the flip. Random bounce bursts catch outputs that chatter or strobes that fire twice, and a latency measurement catches a missing or extra synchronizer stage.

// File: rtl/debounce_pkg.sv
package debounce_pkg;
  // Action chosen by the run counter each cycle.
  typedef enum logic [1:0] {
    CNT_CLEAR = 2'd0,
    CNT_RUN   = 2'd1,
    CNT_FIRE  = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg_q[0] <= IDLE;
        else     stg_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg_q[i] <= IDLE;
        else     stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/run_counter.sv
module run_counter
  import debounce_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic mismatch_i,
  output logic fire_o
);
  localparam logic [W-1:0] LIMIT = {W{1'b1}};

  logic [W-1:0] cnt_q;
  cnt_act_e     act;

  always_comb begin
    if (!mismatch_i)         act = CNT_CLEAR;
    else if (cnt_q == LIMIT) act = CNT_FIRE;
    else                     act = CNT_RUN;
  end

  assign fire_o = (act == CNT_FIRE);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else begin
      case (act)
        CNT_RUN: cnt_q <= cnt_q + 1'b1;
        default: cnt_q <= '0;
      endcase
    end
  end

  // R3: every disagreeing cycle below the limit advances the run by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    (mismatch_i && cnt_q != LIMIT) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

  // R4: one agreeing cycle restarts the timing
  a_r4_clear_on_agree: assert property (@(posedge clk) disable iff (rst)
    !mismatch_i |=> (cnt_q == '0));

  // R5: the run restarts from zero after an accepted change
  a_r5_restart_after_fire: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> (cnt_q == '0));
endmodule

// File: rtl/level_hold.sv
module level_hold #(
  parameter logic IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic flip_i,
  output logic level_o,
  output logic change_o
);
  logic level_q;
  logic chg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= IDLE;
      chg_q   <= 1'b0;
    end else begin
      chg_q <= flip_i;
      if (flip_i) level_q <= ~level_q;
    end
  end

  assign level_o  = level_q;
  assign change_o = chg_q;

  // R6: the strobe never lasts two cycles
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
    chg_q |=> !chg_q);

  // R6: every visible level change carries the strobe
  a_r6_strobe_marks_change: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> chg_q);
endmodule

// File: rtl/switch_debouncer.sv
module switch_debouncer #(
  parameter int   CNT_W       = 16,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LVL    = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic btn_clean,
  output logic btn_changed
);
  logic synced;
  logic mismatch;
  logic fire;

  sync_chain #(.STAGES(SYNC_STAGES), .IDLE(IDLE_LVL)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (btn_raw),
    .sync_o  (synced)
  );

  assign mismatch = (synced != btn_clean);

  run_counter #(.W(CNT_W)) u_run (
    .clk        (clk),
    .rst        (rst),
    .mismatch_i (mismatch),
    .fire_o     (fire)
  );

  level_hold #(.IDLE(IDLE_LVL)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .flip_i   (fire),
    .level_o  (btn_clean),
    .change_o (btn_changed)
  );

  // R3: the output only moves toward a synchronized input that disagreed with it
  a_r3_flip_only_on_mismatch: assert property (@(posedge clk) disable iff (rst)
    (btn_clean != $past(btn_clean)) |-> ($past(synced) != $past(btn_clean)));
endmodule

// File: tb/sim_switch_debouncer.sv
module sim_switch_debouncer;
  localparam int W     = 4;
  localparam int WIN   = 1 << W;
  localparam int LIMIT = WIN - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b0;
  logic clean, chg;

  int checks = 0, errors = 0;
  int changes = 0, strobes = 0;
  logic prev_clean = 1'b0;

  // reference state derived from the requirements
  logic m_s1, m_s2, m_clean, m_chg;
  int   m_cnt;

  always #4 clk = ~clk;

  switch_debouncer #(.CNT_W(W), .SYNC_STAGES(2), .IDLE_LVL(1'b0)) u0 (
    .clk(clk), .rst(rst), .btn_raw(raw), .btn_clean(clean), .btn_changed(chg)
  );

  function automatic logic flip_due(logic s, logic c, int n);
    return (s != c) && (n == LIMIT);
  endfunction

  task automatic model_edge(input logic v);
    logic f;
    if (rst) begin
      m_s1 = 1'b0; m_s2 = 1'b0; m_clean = 1'b0; m_chg = 1'b0; m_cnt = 0;
    end else begin
      f = flip_due(m_s2, m_clean, m_cnt);
      m_chg = f;
      if (m_s2 == m_clean || f) m_cnt = 0; else m_cnt = m_cnt + 1;
      if (f) m_clean = ~m_clean;
      m_s2 = m_s1;
      m_s1 = v;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic v);
    raw = v;
    @(posedge clk);
    model_edge(v);
    @(negedge clk);
    checks++;
    if (clean !== m_clean || chg !== m_chg) begin
      errors++;
      $display("FAIL R3 cycle model: clean=%0b/%0b chg=%0b/%0b (actual/expected)",
               clean, m_clean, chg, m_chg);
    end
    if (!rst && clean != prev_clean) changes++;
    if (!rst && chg) strobes++;
    prev_clean = clean;
  endtask

  task automatic hold(input logic v, input int n);
    for (int i = 0; i < n; i++) step(v);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int base, lat;
    logic tgt;
    void'($urandom(32'h1d5e_0b07));
    @(negedge clk);
    rst = 1'b1;
    hold(1'b1, 3);       // raw active during reset must not matter
    // R1: reset level
    check(clean == 1'b0 && chg == 1'b0, "R1 reset state", int'(clean), 0);
    rst = 1'b0;
    step(1'b0);
    check(clean == 1'b0 && chg == 1'b0, "R1 first cycle after reset", int'(clean), 0);
    hold(1'b0, 4);

    // R2: latency from first sampling edge to visible change
    lat = 0;
    base = changes;
    for (int i = 0; i < 40 && changes == base; i++) begin
      step(1'b1);
      lat++;
    end
    check(lat == WIN + 2, "R2 latency", lat, WIN + 2);
    check(chg == 1'b1, "R6 strobe with change", int'(chg), 1);
    step(1'b1);
    check(chg == 1'b0, "R6 strobe single cycle", int'(chg), 0);
    hold(1'b1, 4);

    // R3: one cycle short of the window is rejected
    base = changes;
    hold(1'b0, WIN - 1);
    hold(1'b1, WIN + 4);
    check(changes == base, "R3 short run rejected", changes - base, 0);
    // R3: exactly the window is accepted
    hold(1'b0, WIN);
    hold(1'b0, 2);
    check(clean == 1'b0 && changes == base + 1, "R3 exact window accepted", changes - base, 1);
    hold(1'b0, 4);

    // R4: a single agreeing cycle restarts timing
    base = changes;
    hold(1'b1, WIN - 2);
    step(1'b0);
    hold(1'b1, WIN - 2);
    step(1'b0);
    hold(1'b0, 4);
    check(changes == base, "R4 interrupted run rejected", changes - base, 0);

    // R5: return right after a change needs a fresh window
    base = changes;
    hold(1'b1, WIN + 2);           // change lands on the last of these
    check(changes == base + 1, "R5 setup change", changes - base, 1);
    hold(1'b0, WIN - 1);
    hold(1'b1, 6);
    check(changes == base + 1 && clean == 1'b1, "R5 early reversal rejected", changes - base, 1);

    // R7: random bounce bursts, then a stable hold
    for (int ph = 0; ph < 150; ph++) begin
      logic v;
      int runs;
      base = changes;
      tgt  = ~clean;
      runs = 1 + int'($urandom % 6);
      v    = tgt;
      for (int r = 0; r < runs; r++) begin
        hold(v, 1 + int'($urandom % (WIN - 1)));
        v = ~v;
      end
      check(changes == base, "R7 burst left output alone", changes - base, 0);
      hold(tgt, WIN + 2 + int'($urandom % 8));
      check(changes == base + 1 && clean == tgt, "R7 one change after hold", changes - base, 1);
    end
    check(strobes == changes, "R6 strobe count equals change count", strobes, changes);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule